// File: doc/BRIEF.md
# Programmable Clock Divider with Interrupt Pin Shaper

This block sits next to the master clock input of a measurement chip. It divides the master clock by a ratio K between 1 and 16 and produces the slow internal data clock as a one-cycle enable, so all downstream logic stays on the single master clock. A 4-bit ratio code selects K, and a code of zero selects the largest ratio, 16. The block also drives a clock output for an external processor. That output is the complement of the master clock unless a pass-through bit is set.

The third function is the shaping of one internal interrupt request onto an external pin. In level mode the pin follows the request. In pulse mode a rising request produces one pulse lasting two periods of the divided clock. A polarity bit chooses whether the active state is high or low in either mode. A ratio change takes effect only when the divider wraps, so an enable period is never cut short.

Top module: `clkdiv_intr_top`

## Requirements
- R1: For ratio codes 1 to 15, `dclk_en` is high for one cycle in every K master cycles, where K equals the code.
- R2: A ratio code of 0 gives a divide ratio of 16.
- R3: After reset is released, the first `dclk_en` cycle follows the K-th rising clock edge.
- R4: A new ratio code written during a period does not change the current period. It takes effect from the next period on.
- R5: With `cpu_clk_pass` = 0, `cpu_clk` is the logical inverse of `clk`.
- R6: With `cpu_clk_pass` = 1, `cpu_clk` equals `clk`.
- R7: With `irq_pulse_mode` = 0 and `irq_active_high` = 0, `irq_pin` is low while the request is high and high otherwise. It lags `irq_req` by one clock.
- R8: With `irq_pulse_mode` = 0 and `irq_active_high` = 1, `irq_pin` copies `irq_req` with a one-clock lag.
- R9: With `irq_pulse_mode` = 1, a rising edge on `irq_req` makes `irq_pin` active for exactly 2*K master cycles, starting one clock later. The active level is high when `irq_active_high` = 1 and low when it is 0.
- R10: In pulse mode, a rising request edge that arrives during a pulse neither stretches nor restarts it. A request that is held high produces only one pulse.
- R11: While `rst` is high, `dclk_en` is 0 and `irq_pin` is at its inactive level (the inverse of `irq_active_high`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | 4 | Divide ratio code, 0 means 16 |
| cpu_clk_pass | input | 1 | 1 passes the master clock to `cpu_clk` without inversion |
| irq_pulse_mode | input | 1 | 0 selects level mode, 1 selects pulse mode |
| irq_active_high | input | 1 | 1 makes the active pin level high |
| irq_req | input | 1 | Internal interrupt request |
| dclk_en | output | 1 | Divided clock enable, one master cycle wide |
| cpu_clk | output | 1 | Processor clock output |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The hardest case to reach is a second request edge that lands inside a running pulse. To produce it, the request must fall and rise again within the 2*K-cycle window, and that window depends on the ratio latched at the last divider wrap. The bench sets the ratio before reset and toggles the request at fixed cycle offsets inside a known window. It then counts the active cycles over a window longer than any legal pulse. The mid-period ratio change is reached by writing the new code in the cycle right after an enable, then timing the two periods that follow.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int RATIO_W_DEF = 4;

  typedef struct packed {
    logic pulse;
    logic act_high;
  } irq_cfg_t;
endpackage

// File: rtl/kdiv_counter.sv
module kdiv_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_code,
  output logic         en,
  output logic [W:0]   k_act
);
  localparam int MAX = 1 << W;

  logic [W-1:0] cnt;
  logic [W:0]   k_req;
  logic         wrap;

  assign k_req = (ratio_code == '0) ? (W+1)'(MAX) : {1'b0, ratio_code};
  assign wrap  = ({1'b0, cnt} == (k_act - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      k_act <= k_req;
      en    <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      k_act <= k_req;
      en    <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      en    <= 1'b0;
    end
  end
endmodule

// File: rtl/cpuclk_sel.sv
module cpuclk_sel (
  input  logic clk,
  input  logic pass,
  output logic cpu_clk
);
  assign cpu_clk = pass ? clk : ~clk;
endmodule

// File: rtl/irq_shaper.sv
module irq_shaper
  import clkdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic [W:0] k_act,
  input  irq_cfg_t cfg,
  input  logic     req,
  output logic     pin
);
  localparam int PW = W + 2;

  logic [PW-1:0] pcnt, pcnt_nx;
  logic          req_q;
  logic          rise;
  logic          active;

  assign rise = req & ~req_q;

  always_comb begin
    if (pcnt != '0)
      pcnt_nx = pcnt - 1'b1;
    else if (rise && cfg.pulse)
      pcnt_nx = {k_act, 1'b0};
    else
      pcnt_nx = '0;
    active = cfg.pulse ? (pcnt_nx != '0) : req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      req_q <= req;
      pin   <= ~cfg.act_high;
    end else begin
      pcnt  <= pcnt_nx;
      req_q <= req;
      pin   <= cfg.act_high ? active : ~active;
    end
  end
endmodule

// File: rtl/clkdiv_intr_top.sv
module clkdiv_intr_top
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = RATIO_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_code,
  input  logic               cpu_clk_pass,
  input  logic               irq_pulse_mode,
  input  logic               irq_active_high,
  input  logic               irq_req,
  output logic               dclk_en,
  output logic               cpu_clk,
  output logic               irq_pin
);
  logic [RATIO_W:0] k_act;
  irq_cfg_t         cfg;

  assign cfg.pulse    = irq_pulse_mode;
  assign cfg.act_high = irq_active_high;

  kdiv_counter #(.W(RATIO_W)) u_div (
    .clk(clk), .rst(rst), .ratio_code(ratio_code),
    .en(dclk_en), .k_act(k_act)
  );

  cpuclk_sel u_cpu (
    .clk(clk), .pass(cpu_clk_pass), .cpu_clk(cpu_clk)
  );

  irq_shaper #(.W(RATIO_W)) u_irq (
    .clk(clk), .rst(rst), .k_act(k_act), .cfg(cfg),
    .req(irq_req), .pin(irq_pin)
  );
endmodule

// File: rtl/clkdiv_intr_chk.sv
module clkdiv_intr_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ratio_code,
  input logic         dclk_en,
  input logic         irq_pin,
  input logic         irq_pulse_mode,
  input logic         irq_active_high,
  input logic         irq_req
);
  localparam int MAX = 1 << W;

  logic [W+1:0] gap;
  logic [W:0]   exp_k;
  logic [W-1:0] code_q;
  logic         valid;

  always_ff @(posedge clk) begin
    code_q <= ratio_code;
    if (rst) begin
      gap   <= '0;
      exp_k <= '0;
      valid <= 1'b0;
    end else if (dclk_en) begin
      gap   <= 1;
      exp_k <= (code_q == '0) ? (W+1)'(MAX) : {1'b0, code_q};
      valid <= 1'b1;
    end else begin
      gap   <= gap + 1'b1;
    end
  end

  // R1
  en_period_chk: assert property (@(posedge clk) disable iff (rst)
    (dclk_en && valid) |-> (gap == {1'b0, exp_k}));

  // R11
  rst_en_chk: assert property (@(posedge clk)
    rst |=> !dclk_en);

  // R11
  rst_pin_chk: assert property (@(posedge clk)
    rst |=> (irq_pin == !$past(irq_active_high)));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_pulse_mode |=>
      (irq_pin == ($past(irq_active_high) ? $past(irq_req) : !$past(irq_req))));
endmodule

bind clkdiv_intr_top clkdiv_intr_chk #(.W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .ratio_code(ratio_code), .dclk_en(dclk_en),
  .irq_pin(irq_pin), .irq_pulse_mode(irq_pulse_mode),
  .irq_active_high(irq_active_high), .irq_req(irq_req)
);

// File: tb/sim_clkdiv_intr_top.sv
module sim_clkdiv_intr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_code = 4'd1;
  logic       cpu_clk_pass = 1'b0;
  logic       irq_pulse_mode = 1'b0;
  logic       irq_active_high = 1'b0;
  logic       irq_req = 1'b0;
  logic       dclk_en, cpu_clk, irq_pin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clkdiv_intr_top u0 (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .cpu_clk_pass(cpu_clk_pass),
    .irq_pulse_mode(irq_pulse_mode), .irq_active_high(irq_active_high),
    .irq_req(irq_req), .dclk_en(dclk_en), .cpu_clk(cpu_clk), .irq_pin(irq_pin)
  );

  localparam int NV = 6;
  localparam logic [3:0] VCODE [NV] = '{4'd1, 4'd2, 4'd5, 4'd15, 4'd0, 4'd8};
  localparam int         VPER  [NV] = '{1, 2, 5, 15, 16, 8};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 en in reset", int'(dclk_en), 0);
    chk("R11 pin in reset", int'(irq_pin), int'(!irq_active_high));
    rst = 1'b0;
  endtask

  task automatic cycles_to_en(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dclk_en && n < 100);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int act_cnt;
    @(negedge clk);

    // Divider table: R1, R2, R3
    for (int i = 0; i < NV; i++) begin
      ratio_code = VCODE[i];
      do_reset();
      cycles_to_en(n);
      chk("R3 first enable", n, VPER[i]);
      cycles_to_en(n);
      chk(VCODE[i] == 4'd0 ? "R2 period code0" : "R1 period", n, VPER[i]);
    end

    // R4: change ratio right after an enable
    ratio_code = 4'd4;
    do_reset();
    cycles_to_en(n);
    ratio_code = 4'd2;
    cycles_to_en(n);
    chk("R4 old period kept", n, 4);
    cycles_to_en(n);
    chk("R4 new period", n, 2);

    // R5, R6: processor clock
    cpu_clk_pass = 1'b0;
    @(negedge clk); #1;
    chk("R5 cpu low phase", int'(cpu_clk), 1);
    @(posedge clk); #5;
    chk("R5 cpu high phase", int'(cpu_clk), 0);
    cpu_clk_pass = 1'b1;
    @(negedge clk); #1;
    chk("R6 cpu low phase", int'(cpu_clk), 0);
    @(posedge clk); #5;
    chk("R6 cpu high phase", int'(cpu_clk), 1);

    // R7: level, active low
    @(negedge clk);
    irq_pulse_mode = 1'b0; irq_active_high = 1'b0; irq_req = 1'b0;
    do_reset();
    irq_req = 1'b1;
    @(negedge clk);
    chk("R7 asserted", int'(irq_pin), 0);
    repeat (3) @(negedge clk);
    chk("R7 held", int'(irq_pin), 0);
    irq_req = 1'b0;
    @(negedge clk);
    chk("R7 released", int'(irq_pin), 1);

    // R8: level, active high
    irq_active_high = 1'b1;
    @(negedge clk);
    chk("R8 idle", int'(irq_pin), 0);
    irq_req = 1'b1;
    @(negedge clk);
    chk("R8 asserted", int'(irq_pin), 1);
    irq_req = 1'b0;
    @(negedge clk);
    chk("R8 released", int'(irq_pin), 0);

    // R9: high pulse with K=3
    ratio_code = 4'd3; irq_pulse_mode = 1'b1; irq_active_high = 1'b1;
    do_reset();
    irq_req = 1'b1;
    act_cnt = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (irq_pin) act_cnt++;
    end
    chk("R9 high pulse width", act_cnt, 6);
    irq_req = 1'b0;

    // R9: low pulse with K=16
    ratio_code = 4'd0; irq_active_high = 1'b0;
    do_reset();
    irq_req = 1'b1;
    act_cnt = 0;
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      if (!irq_pin) act_cnt++;
    end
    chk("R9 low pulse width", act_cnt, 32);
    irq_req = 1'b0;

    // R10: re-trigger inside the pulse, then request held high
    ratio_code = 4'd3; irq_active_high = 1'b1;
    do_reset();
    irq_req = 1'b1;
    act_cnt = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (irq_pin) act_cnt++;
      if (c == 1) irq_req = 1'b0;
      if (c == 2) irq_req = 1'b1;
    end
    chk("R10 no stretch or retrigger", act_cnt, 6);
    chk("R10 idle after pulse", int'(irq_pin), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule